// File: doc/BRIEF.md
# Three-Cable Pseudo-Random Link Checker

This block checks three incoming data cables during a link test. Each cable carries sixteen em energy bits and sixteen hadronic energy bits per data cycle. The far end fills them from a 32-bit pseudo-random sequence. The block holds one seed per cable and runs a matching 32-bit generator for each cable. Every clock is one data cycle. In each checked cycle the block compares the received bits with its own generator output and counts the cycles that disagree.

Software loads the seeds through a seed-write strobe with a cable selector. It then raises a test enable. The block waits for the far end's start flag and then checks continuously. Pulling the enable low stops the check, clears the error state and re-arms the block for a new run.

Top module: `prbsLinkChecker`

## Requirements
- R1: After reset, `checkActive`, every bit of `errFlag` and every `errCnt` field are 0.
- R2: When `seedWr` is 1 and `seedGen` is 0, 1 or 2, the seed of that cable takes {`seedHi`,`seedLo`} (`seedHi` forms bits 31:16). A write with `seedGen` equal to 3 changes no seed.
- R3: A stored seed of zero is used as 32'h0000_0001.
- R4: While `testEn` is 0, `checkActive`, `errFlag` and `errCnt` are cleared from the next clock on, and `farStart` has no effect.
- R5: Checking begins in the first cycle with `testEn` = 1 and `farStart` = 1. In that cycle the generator output equals the seed of each cable. `checkActive` is 1 from the next cycle and stays 1 while `testEn` is 1, whatever `farStart` does.
- R6: In each checked cycle the generator advances one step from state s to {s[30:0], s[31]^s[21]^s[1]^s[0]}.
- R7: Em bit i of a cable (field bits [16c+i] of `emBits`) is compared with generator bit 2i. Hadronic bit i (`hadBits`[16c+i]) is compared with generator bit 2i+1.
- R8: Received bits in cycles before checking begins are ignored.
- R9: A checked cycle with any differing bit sets the sticky `errFlag`[c] and adds one to `errCnt`[16c+15:16c]. The change shows after that clock edge. Each cable is counted on its own.
- R10: An error count saturates at 65535.
- R11: A seed write made while checking, or in the cycle checking starts, leaves the running sequence unchanged. The new seed is used from the next arming onward.
- R12: If `testEn` falls in a cycle that also carries a mismatch, clearing wins and the counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| testEn | input | 1 | Test enable: arms the generators and the checking |
| farStart | input | 1 | Start flag received from the far end |
| seedWr | input | 1 | Seed write strobe |
| seedGen | input | 2 | Target cable of the seed write (0 to 2) |
| seedHi | input | 16 | Upper half of the seed |
| seedLo | input | 16 | Lower half of the seed |
| emBits | input | 48 | Em energy bits, 16 per cable, cable c in [16c+15:16c] |
| hadBits | input | 48 | Hadronic energy bits, 16 per cable, same layout |
| checkActive | output | 1 | Start seen: the block is checking |
| errFlag | output | 3 | Sticky mismatch flag per cable |
| errCnt | output | 48 | Saturating mismatch count per cable, cable c in [16c+15:16c] |

## Verification
Two pairs of functions can act in the same cycle.

- **Seed write and first start.** The bench issues a seed write in the very cycle the start flag first rises. It then feeds the sequence of the old seed and expects no error. After a disable and a new arming it feeds the sequence of the new seed and again expects no error.
- **Disable and mismatch.** The bench corrupts every cable in the cycle where the enable drops and expects all counters and flags to be zero afterwards.

In every case the bench computes the expected sequence and counts with its own model of the generator.

// File: rtl/prbsChkPkg.sv
`timescale 1ns/1ps
package prbsChkPkg;
  parameter int unsigned CABLES   = 3;
  parameter int unsigned CHANNELS = 16;
  localparam int unsigned GEN_W   = 2 * CHANNELS;
  localparam int unsigned SEL_W   = $clog2(CABLES + 1);

  typedef struct packed {
    logic [CABLES-1:0] seedLoad;
    logic              run;
    logic              first;
    logic              clear;
  } ctrlStrb_t;

  // Fibonacci step, taps 32, 22, 2, 1 (maximal length)
  function automatic logic [GEN_W-1:0] lfsrStep(input logic [GEN_W-1:0] s);
    return {s[GEN_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction
endpackage

// File: rtl/prbsChkCtrl.sv
`timescale 1ns/1ps
module prbsChkCtrl
  import prbsChkPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             testEn,
  input  logic             farStart,
  input  logic             seedWr,
  input  logic [SEL_W-1:0] seedGen,
  output ctrlStrb_t        strb,
  output logic             checkActive
);
  logic seenQ;
  logic runNow;

  assign runNow = testEn && (seenQ || farStart);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenQ <= 1'b0;
    else       seenQ <= runNow;
  end

  for (genvar c = 0; c < CABLES; c++) begin : g_sel
    assign strb.seedLoad[c] = seedWr && (seedGen == SEL_W'(c));
  end

  assign strb.run     = runNow;
  assign strb.first   = runNow && !seenQ;
  assign strb.clear   = !testEn;
  assign checkActive  = seenQ;
endmodule

// File: rtl/prbsChkLane.sv
`timescale 1ns/1ps
module prbsChkLane
  import prbsChkPkg::*;
#(
  parameter int unsigned           CNT_W     = 16,
  parameter logic [GEN_W-1:0]      ZERO_SEED = 32'h0000_0001
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                seedLoad,
  input  logic                run,
  input  logic                first,
  input  logic                clear,
  input  logic [GEN_W-1:0]    seedVal,
  input  logic [CHANNELS-1:0] emBits,
  input  logic [CHANNELS-1:0] hadBits,
  output logic                errFlag,
  output logic [CNT_W-1:0]    errCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [GEN_W-1:0] seedQ, seedFix, lfsrQ, curGen, rxWord;
  logic             mismatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         seedQ <= '0;
    else if (seedLoad) seedQ <= seedVal;
  end

  assign seedFix = (seedQ == '0) ? ZERO_SEED : seedQ;
  assign curGen  = first ? seedFix : lfsrQ;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_mix
    assign rxWord[2*i]   = emBits[i];
    assign rxWord[2*i+1] = hadBits[i];
  end

  assign mismatch = run && ((curGen ^ rxWord) != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    lfsrQ <= '0;
    else if (run) lfsrQ <= lfsrStep(curGen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      errCnt  <= '0;
    end else if (clear) begin
      errFlag <= 1'b0;
      errCnt  <= '0;
    end else if (mismatch) begin
      errFlag <= 1'b1;
      if (errCnt != CNT_MAX) errCnt <= errCnt + 1'b1;
    end
  end
endmodule

// File: rtl/prbsLinkChecker.sv
`timescale 1ns/1ps
module prbsLinkChecker
  import prbsChkPkg::*;
#(
  parameter int unsigned      CNT_W     = 16,
  parameter logic [GEN_W-1:0] ZERO_SEED = 32'h0000_0001
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         testEn,
  input  logic                         farStart,
  input  logic                         seedWr,
  input  logic [SEL_W-1:0]             seedGen,
  input  logic [CHANNELS-1:0]          seedHi,
  input  logic [CHANNELS-1:0]          seedLo,
  input  logic [CABLES*CHANNELS-1:0]   emBits,
  input  logic [CABLES*CHANNELS-1:0]   hadBits,
  output logic                         checkActive,
  output logic [CABLES-1:0]            errFlag,
  output logic [CABLES*CNT_W-1:0]      errCnt
);
  ctrlStrb_t strb;

  prbsChkCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .testEn(testEn), .farStart(farStart),
    .seedWr(seedWr), .seedGen(seedGen), .strb(strb), .checkActive(checkActive)
  );

  for (genvar c = 0; c < CABLES; c++) begin : g_lane
    prbsChkLane #(.CNT_W(CNT_W), .ZERO_SEED(ZERO_SEED)) u_lane (
      .clk(clk), .rstN(rstN),
      .seedLoad(strb.seedLoad[c]), .run(strb.run), .first(strb.first),
      .clear(strb.clear), .seedVal({seedHi, seedLo}),
      .emBits(emBits[c*CHANNELS +: CHANNELS]),
      .hadBits(hadBits[c*CHANNELS +: CHANNELS]),
      .errFlag(errFlag[c]), .errCnt(errCnt[c*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/prbsChkSva.sv
`timescale 1ns/1ps
module prbsChkSva
  import prbsChkPkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    testEn,
  input logic                    farStart,
  input logic                    checkActive,
  input logic [CABLES-1:0]       errFlag,
  input logic [CABLES*CNT_W-1:0] errCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_clear_on_disable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |=> (!checkActive && errFlag == '0 && errCnt == '0));

  p_start_arms_r5: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && farStart) |=> checkActive);

  p_active_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && checkActive) |=> checkActive);

  p_quiet_before_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && !checkActive && !farStart) |=> $stable(errCnt));

  for (genvar c = 0; c < CABLES; c++) begin : g_c
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
      (testEn && errFlag[c]) |=> errFlag[c]);

    p_step_one_r9: assert property (@(posedge clk) disable iff (!rstN)
      testEn |=> (errCnt[c*CNT_W +: CNT_W] == $past(errCnt[c*CNT_W +: CNT_W]) ||
                  errCnt[c*CNT_W +: CNT_W] == $past(errCnt[c*CNT_W +: CNT_W]) + 1'b1));

    p_flag_matches_cnt_r9: assert property (@(posedge clk) disable iff (!rstN)
      errFlag[c] == (errCnt[c*CNT_W +: CNT_W] != '0));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
      (testEn && errCnt[c*CNT_W +: CNT_W] == CNT_MAX) |=> errCnt[c*CNT_W +: CNT_W] == CNT_MAX);
  end
endmodule

bind prbsLinkChecker prbsChkSva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rstN(rstN), .testEn(testEn), .farStart(farStart),
  .checkActive(checkActive), .errFlag(errFlag), .errCnt(errCnt)
);

// File: tb/prbsLinkChecker_tb.sv
`timescale 1ns/1ps
module prbsLinkChecker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        testEn = 1'b0, farStart = 1'b0, seedWr = 1'b0;
  logic [1:0]  seedGen = '0;
  logic [15:0] seedHi = '0, seedLo = '0;
  logic [47:0] emBits = '0, hadBits = '0;
  logic        checkActive;
  logic [2:0]  errFlag;
  logic [47:0] errCnt;

  int checks = 0, errors = 0;
  logic        done = 1'b0;

  logic [31:0] mSeed [3];
  logic [31:0] mState[3];
  int unsigned mCnt  [3];
  logic        mSeen;

  always #10 clk = ~clk;

  prbsLinkChecker u_dut (
    .clk(clk), .rstN(rstN), .testEn(testEn), .farStart(farStart),
    .seedWr(seedWr), .seedGen(seedGen), .seedHi(seedHi), .seedLo(seedLo),
    .emBits(emBits), .hadBits(hadBits), .checkActive(checkActive),
    .errFlag(errFlag), .errCnt(errCnt)
  );

  function automatic logic [31:0] stepM(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(checkActive == mSeen, req, "checkActive", checkActive, mSeen);
    for (int c = 0; c < 3; c++) begin
      chk(errFlag[c] == (mCnt[c] != 0), req, $sformatf("errFlag[%0d]", c), errFlag[c], mCnt[c] != 0);
      chk(errCnt[c*16 +: 16] == mCnt[c], req, $sformatf("errCnt[%0d]", c), errCnt[c*16 +: 16], mCnt[c]);
    end
  endtask

  // one data cycle; inputs set at negedge, model updated at posedge
  task automatic tick(input logic en, input logic st, input logic wr,
                      input logic [1:0] gen, input logic [31:0] seed,
                      input logic [2:0] corrupt);
    logic        run;
    logic [31:0] cur[3];
    run = en && (mSeen || st);
    for (int c = 0; c < 3; c++) begin
      cur[c] = mSeen ? mState[c] : ((mSeed[c] == 0) ? 32'h1 : mSeed[c]);
      for (int i = 0; i < 16; i++) begin
        emBits[c*16+i]  = run ? cur[c][2*i]   : ~cur[c][2*i];   // R8: junk before start
        hadBits[c*16+i] = run ? cur[c][2*i+1] : ~cur[c][2*i+1];
      end
      if (corrupt[c]) begin  // R7: flip one lane-specific bit
        if (c == 0) emBits[5]       = ~emBits[5];
        if (c == 1) hadBits[16+9]   = ~hadBits[16+9];
        if (c == 2) emBits[32+15]   = ~emBits[32+15];
      end
    end
    testEn = en; farStart = st; seedWr = wr; seedGen = gen;
    seedHi = seed[31:16]; seedLo = seed[15:0];
    @(posedge clk);
    for (int c = 0; c < 3; c++) begin
      if (run) mState[c] = stepM(cur[c]);
      if (!en) mCnt[c] = 0;
      else if (run && corrupt[c] && mCnt[c] != 65535) mCnt[c]++;
    end
    if (wr && gen < 3) mSeed[gen] = seed;
    mSeen = en && (mSeen || st);
    @(negedge clk);
    seedWr = 1'b0;
  endtask

  task automatic t_reset;  // R1
    checkAll("R1");
  endtask

  task automatic t_seedAndRun;  // R2 R3 R5 R6 R7 R8
    tick(0, 0, 1, 2'd0, 32'h1234_5678, 3'b000);
    tick(0, 0, 1, 2'd1, 32'h0000_0000, 3'b000);
    tick(0, 0, 1, 2'd2, 32'hFFFF_0001, 3'b000);
    tick(0, 0, 1, 2'd3, 32'hAAAA_AAAA, 3'b000);
    for (int k = 0; k < 5; k++) tick(1, 0, 0, 0, 0, 3'b111);
    checkAll("R8");
    tick(1, 1, 0, 0, 0, 3'b000);
    checkAll("R5");
    for (int k = 0; k < 40; k++) tick(1, k[0], 0, 0, 0, 3'b000);
    checkAll("R6");
    checkAll("R2");
    checkAll("R3");
  endtask

  task automatic t_errors;  // R9 R7
    tick(1, 0, 0, 0, 0, 3'b010);
    tick(1, 0, 0, 0, 0, 3'b011);
    tick(1, 0, 0, 0, 0, 3'b010);
    checkAll("R9");
    for (int k = 0; k < 10; k++) tick(1, 0, 0, 0, 0, 3'b000);
    checkAll("R7");
  endtask

  task automatic t_seedWhileRun;  // R11
    tick(1, 0, 1, 2'd0, 32'h0BAD_F00D, 3'b000);
    for (int k = 0; k < 15; k++) tick(1, 0, 0, 0, 0, 3'b000);
    checkAll("R11");
  endtask

  task automatic t_disableCollide;  // R12 R4
    tick(0, 0, 0, 0, 0, 3'b111);
    checkAll("R12");
    for (int k = 0; k < 4; k++) tick(0, 1, 0, 0, 0, 3'b111);
    checkAll("R4");
  endtask

  task automatic t_seedAtStart;  // R11
    tick(1, 1, 1, 2'd2, 32'h5A5A_C3C3, 3'b000);
    for (int k = 0; k < 20; k++) tick(1, 0, 0, 0, 0, 3'b000);
    checkAll("R11");
    tick(0, 0, 0, 0, 0, 3'b000);
    tick(1, 1, 0, 0, 0, 3'b000);
    for (int k = 0; k < 20; k++) tick(1, 0, 0, 0, 0, 3'b000);
    checkAll("R11");
  endtask

  task automatic t_saturate;  // R10
    for (int k = 0; k < 65540; k++) tick(1, 0, 0, 0, 0, 3'b100);
    checkAll("R10");
  endtask

  initial begin
    for (int c = 0; c < 3; c++) begin
      mSeed[c] = '0; mState[c] = '0; mCnt[c] = 0;
    end
    mSeen = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_seedAndRun();
    t_errors();
    t_seedWhileRun();
    t_disableCollide();
    t_seedAtStart();
    t_saturate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule